// File: doc/BRIEF.md
# Iterative Multiply Execute Sequencer

This block paces a multiply-class operation through the execute stage of a pipeline. A single multiplier array is re-used for several passes. The number of passes depends on the class of operation. While the array is busy, the block holds the front of the pipeline with a stall signal. It then announces, with one-cycle strobes, when the low result word, the high result word and the condition flags can be consumed. The arithmetic is computed once, when the operation is accepted. The pass count models only the occupancy and the timing at which each result may be used.

An operation is offered with `issue_i`, together with a three-bit class code, two operands and an optional accumulate value. Counting starts at the accepting clock edge. Cycle k is the k-th clock cycle after that edge, so cycle 1 is the first execute pass. Result registers are loaded at the edge that opens their strobe cycle and hold their value until their next load. Widths, pass counts and the memory-stage delay are parameters; the values below use the defaults.

Top module: `mul_seq`

## Requirements
- R1: Class codes and pass counts are: 0 short signed 16x16 (1 pass), 1 short multiply-accumulate (2 passes), 2 word multiply (2), 3 flag-setting word multiply (4), 4 long multiply (3) and 5 flag-setting long multiply (5). `stall_o` is high in cycles 1 to N-1 and low otherwise.
- R2: `lo_valid_o` pulses for exactly one cycle. The cycle depends on the class: cycle 3 for codes 0 and 1, and cycle 4 for codes 2 to 5. `res_lo_o` holds the low word from that cycle on.
- R3: For codes 4 and 5, `hi_valid_o` pulses in cycle 5, one cycle after the low word, and `res_hi_o` holds the high word from then on. Codes 0 to 3 never raise `hi_valid_o` and never alter `res_hi_o`.
- R4: `flags_valid_o` pulses only for codes 3 and 5, in cycle N+1 (cycle 5 and cycle 6 respectively), and never while `stall_o` is high.
- R5: Arithmetic:
  - codes 0 and 1 multiply the signed low halves of `a_i` and `b_i`;
  - code 1 always adds `acc_lo_i`, and code 0 never adds it;
  - codes 2 and 3 give the low 32 bits of `a_i*b_i`, plus `acc_lo_i` when `acc_en_i` is 1;
  - codes 4 and 5 give the 64-bit product, signed when `sgn_i` is 1 and unsigned otherwise, plus {`acc_hi_i`,`acc_lo_i`} when `acc_en_i` is 1.
- R6: `flags_o` is {N,Z}. For code 3, N is bit 31 of the word result and Z is set when that word is zero. For code 5, N is bit 63 and Z is set when all 64 bits are zero.
- R7: `res_lo_o`, `res_hi_o` and `flags_o` change only in the cycle in which their own strobe is high.
- R8: `issue_i` is ignored while an operation is in flight, from the accepting edge through the cycle of its last strobe, whatever class and operands are presented.
- R9: Class codes 6 and 7 are ignored: no stall, no strobe and no output change follow.
- R10: After reset every output is zero.
- R11: An issue sampled at the first edge after the last strobe cycle is accepted, so operations run back to back with a single idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Offer an operation this cycle |
| op_i | input | 3 | Operation class code |
| acc_en_i | input | 1 | Accumulate enable for codes 2 to 5 |
| sgn_i | input | 1 | Signed long multiply when 1 |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| acc_lo_i | input | W | Accumulate value, low word |
| acc_hi_i | input | W | Accumulate value, high word |
| stall_o | output | 1 | Hold the front of the pipeline |
| lo_valid_o | output | 1 | Low result word usable |
| hi_valid_o | output | 1 | High result word usable |
| flags_valid_o | output | 1 | Flags usable |
| res_lo_o | output | W | Low result word |
| res_hi_o | output | W | High result word |
| flags_o | output | 2 | {N,Z} flags |

## Verification
The assertions assume that reset is applied before any issue. They also assume that operands need only be valid at the accepting edge, so they make no claim about inputs seen while the block is busy. The stimulus offers real operations only when the sequencer is idle, or holds one across the last strobe cycle to probe the acceptance boundary. Junk offers are made on purpose only while an operation is in flight or with an undefined class code. In both cases the scoreboard expects the outputs to be left untouched.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

   typedef enum logic [2:0] {
      MS_SHORT     = 3'd0,
      MS_SHORT_ACC = 3'd1,
      MS_WORD      = 3'd2,
      MS_WORD_FLG  = 3'd3,
      MS_LONG      = 3'd4,
      MS_LONG_FLG  = 3'd5
   } ms_op_e;

   // Slot numbers count cycles after the accepting edge (1 = first pass).
   typedef struct packed {
      logic [7:0] passes;
      logic [7:0] lo_at;
      logic [7:0] hi_at;
      logic [7:0] flg_at;
      logic [7:0] last_at;
      logic       is_long;
      logic       set_flags;
   } ms_tim_t;

   function automatic logic [7:0] ms_max(input logic [7:0] x, input logic [7:0] y);
      return (x > y) ? x : y;
   endfunction

endpackage

// File: rtl/mseq_timing.sv
module mseq_timing
   import mseq_pkg::*;
#(
   parameter int P_SHORT     = 1,
   parameter int P_SHORT_ACC = 2,
   parameter int P_WORD      = 2,
   parameter int P_WORD_FLG  = 4,
   parameter int P_LONG      = 3,
   parameter int P_LONG_FLG  = 5,
   parameter int MEM_LAT     = 1
) (
   input  logic [2:0] op_i,
   output ms_tim_t    tim_o,
   output logic       legal_o
);

   // value slot = value passes + 1, plus the memory stage where the class waits for it
   localparam logic [7:0] SH_LO  = 8'(P_SHORT + 1 + MEM_LAT);
   localparam logic [7:0] SA_LO  = 8'(P_SHORT_ACC + 1);
   localparam logic [7:0] WD_LO  = 8'(P_WORD + 1 + MEM_LAT);
   localparam logic [7:0] WF_LO  = 8'(P_WORD_FLG);
   localparam logic [7:0] WF_FL  = 8'(P_WORD_FLG + 1);
   localparam logic [7:0] LG_HI  = 8'(P_LONG + 1 + MEM_LAT);
   localparam logic [7:0] LF_HI  = 8'(P_LONG_FLG);
   localparam logic [7:0] LF_FL  = 8'(P_LONG_FLG + 1);

   ms_tim_t t;

   always_comb begin
      t       = '0;
      legal_o = 1'b1;
      case (op_i)
         MS_SHORT: begin
            t.passes = 8'(P_SHORT);
            t.lo_at  = SH_LO;
         end
         MS_SHORT_ACC: begin
            t.passes = 8'(P_SHORT_ACC);
            t.lo_at  = SA_LO;
         end
         MS_WORD: begin
            t.passes = 8'(P_WORD);
            t.lo_at  = WD_LO;
         end
         MS_WORD_FLG: begin
            t.passes    = 8'(P_WORD_FLG);
            t.lo_at     = WF_LO;
            t.flg_at    = WF_FL;
            t.set_flags = 1'b1;
         end
         MS_LONG: begin
            t.passes  = 8'(P_LONG);
            t.hi_at   = LG_HI;
            t.lo_at   = LG_HI - 8'd1;
            t.is_long = 1'b1;
         end
         MS_LONG_FLG: begin
            t.passes    = 8'(P_LONG_FLG);
            t.hi_at     = LF_HI;
            t.lo_at     = LF_HI - 8'd1;
            t.flg_at    = LF_FL;
            t.is_long   = 1'b1;
            t.set_flags = 1'b1;
         end
         default: legal_o = 1'b0;
      endcase
      t.last_at = ms_max(ms_max(t.lo_at, t.hi_at), t.flg_at);
      tim_o     = t;
   end

endmodule

// File: rtl/mseq_arith.sv
module mseq_arith
   import mseq_pkg::*;
#(
   parameter int W         = 32,
   parameter bit MUL_ARRAY = 1'b1
) (
   input  logic [2:0]     op_i,
   input  logic           acc_en_i,
   input  logic           sgn_i,
   input  logic [W-1:0]   a_i,
   input  logic [W-1:0]   b_i,
   input  logic [W-1:0]   acc_lo_i,
   input  logic [W-1:0]   acc_hi_i,
   output logic [2*W-1:0] sum_o,
   output logic           neg_o,
   output logic           zero_o
);

   localparam int H  = W / 2;
   localparam int DW = 2 * W;

   logic [DW-1:0] opa, opb, acc, prod;
   logic          wide;

   always_comb begin
      opa  = {{W{1'b0}}, a_i};
      opb  = {{W{1'b0}}, b_i};
      acc  = '0;
      wide = 1'b0;
      case (op_i)
         MS_SHORT, MS_SHORT_ACC: begin
            opa = {{(DW-H){a_i[H-1]}}, a_i[H-1:0]};
            opb = {{(DW-H){b_i[H-1]}}, b_i[H-1:0]};
            if (op_i == MS_SHORT_ACC) acc = {{W{1'b0}}, acc_lo_i};
         end
         MS_WORD, MS_WORD_FLG: begin
            if (acc_en_i) acc = {{W{1'b0}}, acc_lo_i};
         end
         MS_LONG, MS_LONG_FLG: begin
            wide = 1'b1;
            if (sgn_i) begin
               opa = {{W{a_i[W-1]}}, a_i};
               opb = {{W{b_i[W-1]}}, b_i};
            end
            if (acc_en_i) acc = {acc_hi_i, acc_lo_i};
         end
         default: ;
      endcase
   end

   generate
      if (MUL_ARRAY) begin : g_array
         // shift-and-add partial-product array
         always_comb begin
            prod = '0;
            for (int i = 0; i < DW; i++) begin
               if (opb[i]) prod = prod + (opa << i);
            end
         end
      end else begin : g_operator
         always_comb prod = opa * opb;
      end
   endgenerate

   always_comb begin
      sum_o  = prod + acc;
      neg_o  = wide ? sum_o[DW-1] : sum_o[W-1];
      zero_o = wide ? (sum_o == '0) : (sum_o[W-1:0] == '0);
   end

endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
   import mseq_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    issue_i,
   input  logic    legal_i,
   input  ms_tim_t tim_i,
   output logic    take_o,
   output logic    busy_o,
   output logic    stall_o,
   output logic    lo_v_o,
   output logic    hi_v_o,
   output logic    fl_v_o,
   output logic    ld_lo_o,
   output logic    ld_hi_o,
   output logic    ld_fl_o
);

   logic       busy;
   logic [7:0] cnt, cnt_nx;
   ms_tim_t    tq;

   assign cnt_nx = cnt + 8'd1;
   assign take_o = issue_i && legal_i && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         tq   <= '0;
      end else if (take_o) begin
         busy <= 1'b1;
         cnt  <= 8'd1;
         tq   <= tim_i;
      end else if (busy) begin
         if (cnt == tq.last_at) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt <= cnt_nx;
         end
      end
   end

   assign busy_o  = busy;
   assign stall_o = busy && (cnt < tq.passes);
   assign lo_v_o  = busy && (cnt == tq.lo_at);
   assign hi_v_o  = busy && tq.is_long && (cnt == tq.hi_at);
   assign fl_v_o  = busy && tq.set_flags && (cnt == tq.flg_at);
   assign ld_lo_o = busy && (cnt_nx == tq.lo_at);
   assign ld_hi_o = busy && tq.is_long && (cnt_nx == tq.hi_at);
   assign ld_fl_o = busy && tq.set_flags && (cnt_nx == tq.flg_at);

endmodule

// File: rtl/mul_seq.sv
module mul_seq
   import mseq_pkg::*;
#(
   parameter int W           = 32,
   parameter bit MUL_ARRAY   = 1'b1,
   parameter int P_SHORT     = 1,
   parameter int P_SHORT_ACC = 2,
   parameter int P_WORD      = 2,
   parameter int P_WORD_FLG  = 4,
   parameter int P_LONG      = 3,
   parameter int P_LONG_FLG  = 5,
   parameter int MEM_LAT     = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         issue_i,
   input  logic [2:0]   op_i,
   input  logic         acc_en_i,
   input  logic         sgn_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] acc_lo_i,
   input  logic [W-1:0] acc_hi_i,
   output logic         stall_o,
   output logic         lo_valid_o,
   output logic         hi_valid_o,
   output logic         flags_valid_o,
   output logic [W-1:0] res_lo_o,
   output logic [W-1:0] res_hi_o,
   output logic [1:0]   flags_o
);

   localparam int DW     = 2 * W;
   localparam int MAX_AT = P_SHORT + P_SHORT_ACC + P_WORD + P_WORD_FLG + P_LONG + P_LONG_FLG + MEM_LAT + 2;

   generate
      if (W < 4 || (W % 2) != 0) begin : g_bad_width
         $error("mul_seq: W must be even and at least 4");
      end
      if (P_SHORT < 1 || P_SHORT_ACC < 1 || P_WORD < 1 || P_LONG < 1) begin : g_bad_pass
         $error("mul_seq: every class needs at least one pass");
      end
      if (P_WORD_FLG < 2 || P_LONG_FLG < 3 || (P_LONG + MEM_LAT) < 2 || MEM_LAT < 0) begin : g_bad_flag
         $error("mul_seq: flag classes need an extra pass beyond their value");
      end
      if (MAX_AT > 250) begin : g_bad_range
         $error("mul_seq: pass counts exceed the slot counter");
      end
   endgenerate

   ms_tim_t       tim;
   logic          legal, take, busy;
   logic          ld_lo, ld_hi, ld_fl;
   logic [DW-1:0] sum, sum_q;
   logic          neg, zero;
   logic [1:0]    nz_q;

   mseq_timing #(
      .P_SHORT(P_SHORT), .P_SHORT_ACC(P_SHORT_ACC), .P_WORD(P_WORD),
      .P_WORD_FLG(P_WORD_FLG), .P_LONG(P_LONG), .P_LONG_FLG(P_LONG_FLG),
      .MEM_LAT(MEM_LAT)
   ) u_timing (
      .op_i    (op_i),
      .tim_o   (tim),
      .legal_o (legal)
   );

   mseq_arith #(.W(W), .MUL_ARRAY(MUL_ARRAY)) u_arith (
      .op_i     (op_i),
      .acc_en_i (acc_en_i),
      .sgn_i    (sgn_i),
      .a_i      (a_i),
      .b_i      (b_i),
      .acc_lo_i (acc_lo_i),
      .acc_hi_i (acc_hi_i),
      .sum_o    (sum),
      .neg_o    (neg),
      .zero_o   (zero)
   );

   mseq_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .issue_i (issue_i),
      .legal_i (legal),
      .tim_i   (tim),
      .take_o  (take),
      .busy_o  (busy),
      .stall_o (stall_o),
      .lo_v_o  (lo_valid_o),
      .hi_v_o  (hi_valid_o),
      .fl_v_o  (flags_valid_o),
      .ld_lo_o (ld_lo),
      .ld_hi_o (ld_hi),
      .ld_fl_o (ld_fl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q    <= '0;
         nz_q     <= '0;
         res_lo_o <= '0;
         res_hi_o <= '0;
         flags_o  <= '0;
      end else begin
         if (take) begin
            sum_q <= sum;
            nz_q  <= {neg, zero};
         end
         if (ld_lo) res_lo_o <= sum_q[W-1:0];
         if (ld_hi) res_hi_o <= sum_q[DW-1:W];
         if (ld_fl) flags_o  <= nz_q;
      end
   end

endmodule

// File: rtl/mul_seq_chk.sv
module mul_seq_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         stall_o,
   input logic         lo_valid_o,
   input logic         hi_valid_o,
   input logic         flags_valid_o,
   input logic [W-1:0] res_lo_o,
   input logic [W-1:0] res_hi_o,
   input logic [1:0]   flags_o
);

   AST_LO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      lo_valid_o |=> !lo_valid_o); // R2

   AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
      hi_valid_o |-> $past(lo_valid_o)); // R3

   AST_FLAGS_UNSTALLED: assert property (@(posedge clk) disable iff (!rst_n)
      flags_valid_o |-> !stall_o); // R4

   AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !lo_valid_o |-> $stable(res_lo_o)); // R7

   AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !hi_valid_o |-> $stable(res_hi_o)); // R7

   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !flags_valid_o |-> $stable(flags_o)); // R7

endmodule

bind mul_seq mul_seq_chk #(.W(W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .stall_o       (stall_o),
   .lo_valid_o    (lo_valid_o),
   .hi_valid_o    (hi_valid_o),
   .flags_valid_o (flags_valid_o),
   .res_lo_o      (res_lo_o),
   .res_hi_o      (res_hi_o),
   .flags_o       (flags_o)
);

// File: tb/mul_seq_tb.sv
module mul_seq_tb;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [31:0] lo;
      logic [31:0] hi;
      logic [1:0]  nz;
      int          npass, lo_at, hi_at, fl_at, last_at;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_i = 1'b0;
   logic [2:0]  op_i = '0;
   logic        acc_en_i = 1'b0, sgn_i = 1'b0;
   logic [31:0] a_i = '0, b_i = '0, acc_lo_i = '0, acc_hi_i = '0;
   logic        stall_o, lo_valid_o, hi_valid_o, flags_valid_o;
   logic [31:0] res_lo_o, res_hi_o;
   logic [1:0]  flags_o;

   int    n_tests = 0, n_fail = 0;
   bit    done = 1'b0;
   item_t q[$];
   item_t cur;
   bit    active = 1'b0;
   int    k = 0;
   logic [31:0] e_lo = '0, e_hi = '0;
   logic [1:0]  e_nz = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mul_seq u_dut (
      .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i),
      .acc_en_i(acc_en_i), .sgn_i(sgn_i), .a_i(a_i), .b_i(b_i),
      .acc_lo_i(acc_lo_i), .acc_hi_i(acc_hi_i), .stall_o(stall_o),
      .lo_valid_o(lo_valid_o), .hi_valid_o(hi_valid_o),
      .flags_valid_o(flags_valid_o), .res_lo_o(res_lo_o),
      .res_hi_o(res_hi_o), .flags_o(flags_o)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic report;
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   // Timing table from R1..R4 (cycles after the accepting edge)
   function automatic item_t timing(input logic [2:0] op);
      item_t t;
      t = '{default: 0};
      case (op)
         3'd0: begin t.npass = 1; t.lo_at = 3; t.last_at = 3; end
         3'd1: begin t.npass = 2; t.lo_at = 3; t.last_at = 3; end
         3'd2: begin t.npass = 2; t.lo_at = 4; t.last_at = 4; end
         3'd3: begin t.npass = 4; t.lo_at = 4; t.fl_at = 5; t.last_at = 5; end
         3'd4: begin t.npass = 3; t.lo_at = 4; t.hi_at = 5; t.last_at = 5; end
         default: begin t.npass = 5; t.lo_at = 4; t.hi_at = 5; t.fl_at = 6; t.last_at = 6; end
      endcase
      return t;
   endfunction

   // Arithmetic from R5 and R6
   function automatic item_t model(input logic [2:0] op, input bit acc, input bit sg,
                                   input logic [31:0] a, input logic [31:0] b,
                                   input logic [31:0] al, input logic [31:0] ah);
      item_t t;
      logic [63:0] p, s;
      t = timing(op);
      if (op <= 3'd1) begin
         p = $signed({{48{a[15]}}, a[15:0]}) * $signed({{48{b[15]}}, b[15:0]});
         s = p + ((op == 3'd1) ? {32'b0, al} : 64'b0);
      end else if (op <= 3'd3) begin
         p = {32'b0, a} * {32'b0, b};
         s = p + (acc ? {32'b0, al} : 64'b0);
      end else begin
         if (sg) p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
         else    p = {32'b0, a} * {32'b0, b};
         s = p + (acc ? {ah, al} : 64'b0);
      end
      t.lo = s[31:0];
      t.hi = s[63:32];
      if (op >= 3'd4) t.nz = {s[63], s == 64'b0};
      else            t.nz = {s[31], s[31:0] == 32'b0};
      return t;
   endfunction

   task automatic drive(input logic [2:0] op, input bit acc, input bit sg,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] al, input logic [31:0] ah);
      issue_i = 1'b1; op_i = op; acc_en_i = acc; sgn_i = sg;
      a_i = a; b_i = b; acc_lo_i = al; acc_hi_i = ah;
   endtask

   // Driver: waits for idle, pushes expectation, offers for one cycle.
   task automatic do_op(input logic [2:0] op, input bit acc, input bit sg,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] al, input logic [31:0] ah);
      do begin @(posedge clk); #1; end while (active || q.size() != 0);
      q.push_back(model(op, acc, sg, a, b, al, ah));
      drive(op, acc, sg, a, b, al, ah);
      @(posedge clk); #1;
      issue_i = 1'b0;
   endtask

   // R8/R11 boundary: offer already in the last strobe cycle and hold for two edges.
   task automatic do_op_early(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
      do begin @(posedge clk); #1; end while (!(active && k == cur.last_at - 1));
      q.push_back(model(op, 1'b0, 1'b1, a, b, 32'd0, 32'd0));
      drive(op, 1'b0, 1'b1, a, b, 32'd0, 32'd0);
      repeat (2) @(posedge clk);
      #1 issue_i = 1'b0;
   endtask

   // R8: junk offer while the sequencer works on an accepted operation.
   task automatic poke_busy(input logic [2:0] op);
      do begin @(posedge clk); #1; end while (!(active && k == 1));
      drive(op, 1'b1, 1'b1, 32'hDEAD_BEEF, 32'h1234_5678, 32'h5555_5555, 32'hAAAA_AAAA);
      @(posedge clk); #1;
      issue_i = 1'b0;
   endtask

   // R9: undefined class codes offered while idle.
   task automatic poke_illegal(input logic [2:0] op);
      do begin @(posedge clk); #1; end while (active || q.size() != 0);
      drive(op, 1'b1, 1'b0, 32'h0000_0003, 32'h0000_0005, 32'h1, 32'h1);
      @(posedge clk); #1;
      issue_i = 1'b0;
      repeat (6) @(posedge clk);
   endtask

   // Monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (active) begin
               k++;
               if (k == cur.lo_at) e_lo = cur.lo;
               if (cur.hi_at != 0 && k == cur.hi_at) e_hi = cur.hi;
               if (cur.fl_at != 0 && k == cur.fl_at) e_nz = cur.nz;
               chk(stall_o == (k < cur.npass), "R1 stall", 64'(stall_o), 64'(k < cur.npass));
               chk(lo_valid_o == (k == cur.lo_at), "R2 lo_valid", 64'(lo_valid_o), 64'(k == cur.lo_at));
               chk(hi_valid_o == (cur.hi_at != 0 && k == cur.hi_at), "R3 hi_valid",
                   64'(hi_valid_o), 64'(cur.hi_at != 0 && k == cur.hi_at));
               chk(flags_valid_o == (cur.fl_at != 0 && k == cur.fl_at), "R4 flags_valid",
                   64'(flags_valid_o), 64'(cur.fl_at != 0 && k == cur.fl_at));
               if (k == cur.last_at) active = 1'b0;
            end else begin
               chk(!stall_o && !lo_valid_o && !hi_valid_o && !flags_valid_o, "R8 R9 idle quiet",
                   {60'b0, stall_o, lo_valid_o, hi_valid_o, flags_valid_o}, 64'b0);
               if (issue_i && q.size() > 0) begin
                  cur = q.pop_front();
                  active = 1'b1;
                  k = 0;
               end
            end
            chk(res_lo_o == e_lo, "R5 R7 res_lo", 64'(res_lo_o), 64'(e_lo));
            chk(res_hi_o == e_hi, "R5 R7 res_hi", 64'(res_hi_o), 64'(e_hi));
            chk(flags_o == e_nz, "R6 R7 flags", 64'(flags_o), 64'(e_nz));
         end
      end
   end

   // Watchdog
   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      report();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R10: reset state
      chk({stall_o, lo_valid_o, hi_valid_o, flags_valid_o} == 4'b0, "R10 strobes", 64'({stall_o, lo_valid_o, hi_valid_o, flags_valid_o}), 64'd0);
      chk(res_lo_o == 0 && res_hi_o == 0 && flags_o == 0, "R10 data", {res_hi_o, res_lo_o}, 64'd0);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);

      // R1 R2 R5: short signed multiply, code 0 (acc_en ignored)
      do_op(3'd0, 1'b1, 1'b0, 32'h1234_FFFE, 32'h0007_0003, 32'h0000_0100, 32'h0);
      do_op(3'd0, 1'b0, 1'b0, 32'h1234_8000, 32'h0000_0002, 32'h0, 32'h0);
      // code 1: always accumulates
      do_op(3'd1, 1'b0, 1'b0, 32'h0000_7FFF, 32'h0000_7FFF, 32'h0000_0005, 32'h0);
      do_op(3'd1, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 32'h0);
      // code 2: word multiply with and without accumulate
      do_op(3'd2, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0002, 32'h0000_0009, 32'h0);
      do_op(3'd2, 1'b1, 1'b0, 32'h0001_0000, 32'h0001_0000, 32'h0000_0007, 32'h0);
      // R4 R6: code 3 flags, zero and negative results
      do_op(3'd3, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0005, 32'h0, 32'h0);
      do_op(3'd3, 1'b1, 1'b0, 32'h8000_0000, 32'h0000_0001, 32'h0000_0000, 32'h0);
      // R3: long multiply, signed and unsigned, accumulate
      do_op(3'd4, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0, 32'h0);
      do_op(3'd4, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0002);
      // R7: word result after long leaves res_hi unchanged
      do_op(3'd2, 1'b0, 1'b0, 32'h0000_0003, 32'h0000_0004, 32'h0, 32'h0);
      // code 5: flag-setting long
      do_op(3'd5, 1'b0, 1'b1, 32'h0000_0000, 32'h1234_5678, 32'h0, 32'h0);
      do_op(3'd5, 1'b0, 1'b0, 32'h8000_0000, 32'h0000_0002, 32'h0, 32'h0);
      do_op(3'd5, 1'b1, 1'b1, 32'hFFFF_FFFD, 32'h0000_0005, 32'h0000_0001, 32'h0000_0000);

      // R8: junk offered mid-operation
      do_op(3'd5, 1'b0, 1'b0, 32'h0000_1111, 32'h0000_2222, 32'h0, 32'h0);
      poke_busy(3'd0);
      do_op(3'd0, 1'b0, 1'b0, 32'h0000_0004, 32'h0000_0005, 32'h0, 32'h0);
      poke_busy(3'd4);

      // R8 R11: offer held across the last strobe cycle, accepted right after
      do_op(3'd3, 1'b0, 1'b0, 32'h0000_0006, 32'h0000_0007, 32'h0, 32'h0);
      do_op_early(3'd4, 32'hFFFF_FFFE, 32'h0000_0003);
      do_op_early(3'd1, 32'h0000_0002, 32'h0000_0003);

      // R9: undefined codes
      poke_illegal(3'd6);
      poke_illegal(3'd7);

      do begin @(posedge clk); #1; end while (active || q.size() != 0);
      repeat (4) @(posedge clk);
      report();
   end

endmodule